// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Tracking

This block turns four reset requests into the internal reset outputs of a chip. The four requests are an external power-on line, a bidirectional open-drain debugger reset line, a watchdog expiry request and a software trigger bit. It drives separate active-low resets for the internal logic, the clock system, an embedded switch core and the PHYs. Each source resets only its own scope. Only power-on samples the boot straps, clears the control registers, restarts the cause history and resets the clock system. The debugger, watchdog and software resets leave the clock running and reuse the boot mode captured at the last power-on.

Both external lines pass through a filter that counts consecutive sampled cycles. The filter accepts a level only after it has held for `FILT_LEN` samples in a row. Any accepted source reloads a stretch counter. The internal reset stays asserted until `STRETCH` cycles pass with no source active. Reset assertion reaches the outputs at once. Release passes through a two-flop synchroniser. While power-on is active or its stretch is running, the block pulls the debugger line low. This lets an external probe see the power-on phase.

Firmware uses a 2-bit address, 8-bit data register port to do four things: trigger a software reset, enable the switch-core reset for watchdog and software resets, pick the PHY reset source, and read the reset cause and the latched boot straps.

Top module: `rst_ctrl`

## Requirements
- R1: A low pulse on `rst_ni` or on `dbg_rst_ni` that lasts fewer than `FILT_LEN` consecutive sampled cycles has no effect on any output. A low level held for `FILT_LEN` samples is accepted as a reset.
- R2: `dbg_rst_oe_o` is 1 while power-on is accepted and while its stretch runs, and 0 otherwise. Debugger, watchdog and software resets never raise it.
- R3: `sys_rst_no` falls in the cycle after an accepted source is registered. It rises `STRETCH+3` clock edges after the first edge at which no source is seen. For a one-cycle watchdog or software request, that is edge `STRETCH+3` counted from the request edge. For a released external line, it is edge `FILT_LEN+STRETCH+3` counted from the first high sample.
- R4: `clk_rst_no` is driven low only by power-on. It has the same release timing as `sys_rst_no`. Debugger, watchdog and software resets leave it high.
- R5: The boot straps are captured while power-on is accepted. `boot_mode_o` and register 3 (straps in bits [BOOT_W-1:0]) keep that value through the other resets and through later strap changes.
- R6: Register 1 holds the reset cause: bit 0 is power-on or debugger, bit 1 is watchdog, bit 2 is software. Power-on sets it to 3'b001. Every other reset ORs in its own bit, and no reset other than power-on clears a bit.
- R7: Writing 1 to register 0 bit 0 starts a full internal reset. The bit reads 1 while that reset runs and reads 0 once `sys_rst_no` has been released.
- R8: `core_rst_no` is asserted by power-on and by debugger resets. Watchdog and software resets assert it only when register 0 bit 1 is 1, and then with the same timing as `sys_rst_no`. It is never low while `sys_rst_no` is high.
- R9: When register 2 bit 0 is 0, `phy_rst_no` follows `clk_rst_no`, and `mgmt_en_i` and `sw_phy_rst_ni` have no effect. When the bit is 1, `phy_rst_no` is low whenever `sw_phy_rst_ni` is low or `mgmt_en_i` is 0.
- R10: Register 0 bit 1 and register 2 bit 0 are cleared by power-on only. They keep their values through debugger, watchdog and software resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, free-running |
| rst_ni | input | 1 | External power-on reset line, active low, filtered |
| dbg_rst_ni | input | 1 | Sensed level of the open-drain debugger reset line |
| dbg_rst_oe_o | output | 1 | Pull the debugger reset line low |
| wd_req_i | input | 1 | Watchdog expiry request, active high |
| boot_i | input | BOOT_W | Boot strap pins |
| mgmt_en_i | input | 1 | Switch management interface enabled |
| sw_phy_rst_ni | input | 1 | PHY reset from the switch core, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational |
| boot_mode_o | output | BOOT_W | Boot mode latched at the last power-on |
| sys_rst_no | output | 1 | Internal logic reset, active low |
| clk_rst_no | output | 1 | Clock system reset, active low |
| core_rst_no | output | 1 | Switch core reset, active low |
| phy_rst_no | output | 1 | PHY reset, active low |

## Verification
The hardest case to reach is a debugger reset that must not be confused with the block's own pull on the same wire. When power-on releases, the block lets go of the line in the same cycle the line goes high again, and nothing may be read as a debugger reset. The bench models the wire as a wired-AND of its own driver and the block's enable, walks through the whole power-on release cycle by cycle, and then drives the line from outside. Glitch widths from one sample up to the filter length are swept on both lines, and the outputs are watched every cycle for any stray assertion.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_CAUSE = 2'd1,
    REG_PHY   = 2'd2,
    REG_BOOT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_SWRST_BIT = 0;
  localparam int unsigned CTRL_CORE_EN_BIT = 1;
  localparam int unsigned PHY_SEL_BIT = 0;

  localparam int unsigned CAUSE_HW = 0;
  localparam int unsigned CAUSE_WD = 1;
  localparam int unsigned CAUSE_SW = 2;
  localparam int unsigned CAUSE_W = 3;

  // order of the synchronised reset domains
  localparam int unsigned DOM_SYS = 0;
  localparam int unsigned DOM_CLK = 1;
  localparam int unsigned DOM_CORE = 2;
  localparam int unsigned DOM_N = 3;
endpackage

// File: rtl/rst_glitch_filt.sv
module rst_glitch_filt #(
  parameter int unsigned LEN = 3
) (
  input  logic clk_i,
  input  logic line_ni,
  output logic act_o
);
  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;
  logic           act_q;

  generate
    if (LEN == 1) begin : g_single
      assign hist_d = line_ni;
    end else begin : g_shift
      assign hist_d = {hist_q[LEN-2:0], line_ni};
    end
  endgenerate

  // no reset: this filter qualifies the reset itself
  always_ff @(posedge clk_i) begin
    hist_q <= hist_d;
    if (hist_q == '0) act_q <= 1'b1;
    else if (&hist_q) act_q <= 1'b0;
  end

  assign act_o = act_q;
endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) ff_q <= '0;
    else          ff_q <= {ff_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = ff_q[STAGES-1];
endmodule

// File: rtl/rst_ctrl_regs.sv
module rst_ctrl_regs
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned BOOT_W = 4
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               hw_i,
  input  logic               wd_i,
  input  logic               done_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [BOOT_W-1:0]  boot_i,
  output logic [DW-1:0]      rdata_o,
  output logic               sw_wr_o,
  output logic               sw_pend_o,
  output logic               core_en_o,
  output logic               phy_sel_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [BOOT_W-1:0]  boot_o
);
  logic               sw_pend_q, core_en_q, phy_sel_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [BOOT_W-1:0]  boot_q;
  logic               wr_ctrl, wr_phy;
  logic               unused_wdata;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign wr_phy  = we_i && (addr_i == REG_PHY);
  assign sw_wr_o = wr_ctrl && wdata_i[CTRL_SWRST_BIT] && !por_i;
  assign unused_wdata = ^wdata_i;

  // loaded while power-on is held; everything else survives other resets
  always_ff @(posedge clk_i) begin
    if (por_i) begin
      cause_q   <= CAUSE_W'(1) << CAUSE_HW;
      boot_q    <= boot_i;
      core_en_q <= 1'b0;
      phy_sel_q <= 1'b0;
      sw_pend_q <= 1'b0;
    end else begin
      if (hw_i)    cause_q[CAUSE_HW] <= 1'b1;
      if (wd_i)    cause_q[CAUSE_WD] <= 1'b1;
      if (sw_wr_o) cause_q[CAUSE_SW] <= 1'b1;
      if (sw_wr_o)     sw_pend_q <= 1'b1;
      else if (done_i) sw_pend_q <= 1'b0;
      if (wr_ctrl) core_en_q <= wdata_i[CTRL_CORE_EN_BIT];
      if (wr_phy)  phy_sel_q <= wdata_i[PHY_SEL_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_SWRST_BIT]   = sw_pend_q;
        rdata_o[CTRL_CORE_EN_BIT] = core_en_q;
      end
      REG_CAUSE: rdata_o[CAUSE_W-1:0] = cause_q;
      REG_PHY:   rdata_o[PHY_SEL_BIT] = phy_sel_q;
      default:   rdata_o[BOOT_W-1:0] = boot_q;
    endcase
  end

  assign sw_pend_o = sw_pend_q;
  assign core_en_o = core_en_q;
  assign phy_sel_o = phy_sel_q;
  assign cause_o   = cause_q;
  assign boot_o    = boot_q;
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned STRETCH = 16,
  parameter int unsigned BOOT_W = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_rst_ni,
  output logic              dbg_rst_oe_o,
  input  logic              wd_req_i,
  input  logic [BOOT_W-1:0] boot_i,
  input  logic              mgmt_en_i,
  input  logic              sw_phy_rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [BOOT_W-1:0] boot_mode_o,
  output logic              sys_rst_no,
  output logic              clk_rst_no,
  output logic              core_rst_no,
  output logic              phy_rst_no
);
  localparam int unsigned CNT_W = $clog2(STRETCH + 1);

  logic               por_f, hw_f, dbg_line;
  logic               sw_wr, sw_pend, core_en, phy_sel;
  logic [CAUSE_W-1:0] cause;
  logic               src_any, core_trig, done;
  logic [CNT_W-1:0]   cnt_q;
  logic               req_q, por_ph_q, core_ph_q;
  logic [DOM_N-1:0]   dom_req, dom_rst_n;

  rst_glitch_filt #(.LEN(FILT_LEN)) u_por_filt (
    .clk_i  (clk_i),
    .line_ni(rst_ni),
    .act_o  (por_f)
  );

  // own pull on the debugger line must not read back as a debugger reset
  assign dbg_line     = dbg_rst_ni | dbg_rst_oe_o;
  assign dbg_rst_oe_o = por_f | por_ph_q;

  rst_glitch_filt #(.LEN(FILT_LEN)) u_dbg_filt (
    .clk_i  (clk_i),
    .line_ni(dbg_line),
    .act_o  (hw_f)
  );

  rst_ctrl_regs #(.DW(DW), .BOOT_W(BOOT_W)) u_regs (
    .clk_i    (clk_i),
    .por_i    (por_f),
    .hw_i     (hw_f),
    .wd_i     (wd_req_i),
    .done_i   (done),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .boot_i   (boot_i),
    .rdata_o  (reg_rdata_o),
    .sw_wr_o  (sw_wr),
    .sw_pend_o(sw_pend),
    .core_en_o(core_en),
    .phy_sel_o(phy_sel),
    .cause_o  (cause),
    .boot_o   (boot_mode_o)
  );

  assign src_any   = por_f | hw_f | wd_req_i | sw_wr;
  assign core_trig = por_f | hw_f | (core_en & (wd_req_i | sw_wr));
  assign done      = !src_any && (cnt_q <= CNT_W'(1));

  // sequencer is loaded by power-on itself, so it needs no reset
  always_ff @(posedge clk_i) begin
    if (src_any)           cnt_q <= CNT_W'(STRETCH);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    req_q     <= !done;
    por_ph_q  <= por_f | (por_ph_q & !done);
    core_ph_q <= core_trig | (core_ph_q & !done);
  end

  assign dom_req[DOM_SYS]  = req_q;
  assign dom_req[DOM_CLK]  = por_ph_q;
  assign dom_req[DOM_CORE] = core_ph_q;

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    rst_sync #(.STAGES(2)) u_sync (
      .clk_i  (clk_i),
      .arst_ni(!dom_req[d]),
      .rst_no (dom_rst_n[d])
    );
  end

  assign sys_rst_no  = dom_rst_n[DOM_SYS];
  assign clk_rst_no  = dom_rst_n[DOM_CLK];
  assign core_rst_no = dom_rst_n[DOM_CORE];
  assign phy_rst_no  = phy_sel ? (sw_phy_rst_ni & mgmt_en_i) : clk_rst_no;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk #(
  parameter int unsigned BOOT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_f,
  input logic              req_q,
  input logic              sw_pend,
  input logic [2:0]        cause,
  input logic              dbg_rst_oe_o,
  input logic              sys_rst_no,
  input logic              clk_rst_no,
  input logic              core_rst_no,
  input logic [BOOT_W-1:0] boot_mode_o
);
  p_clk_rst_por_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_rst_no) |-> dbg_rst_oe_o);

  p_sys_assert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> !sys_rst_no);

  p_sys_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (!$past(req_q) && !$past(req_q, 2)));

  p_core_in_sys_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_no |-> !sys_rst_no);

  p_cause_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(cause) & ~cause)) |-> $past(por_f));

  p_boot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(por_f) |-> $stable(boot_mode_o));

  p_sw_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_pend) |-> !req_q);
endmodule

bind rst_ctrl rst_ctrl_chk #(.BOOT_W(BOOT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_f       (por_f),
  .req_q       (req_q),
  .sw_pend     (sw_pend),
  .cause       (cause),
  .dbg_rst_oe_o(dbg_rst_oe_o),
  .sys_rst_no  (sys_rst_no),
  .clk_rst_no  (clk_rst_no),
  .core_rst_no (core_rst_no),
  .boot_mode_o (boot_mode_o)
);

// File: tb/sim_rst_ctrl.sv
module sim_rst_ctrl;
  localparam int FL = 3;
  localparam int ST = 16;
  localparam int DB = 6;

  logic       clk = 1'b0;
  logic       rst_ni, dbg_drv, wd_req, mgmt_en, sw_phy_n, we;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rv;
  logic [3:0] boot, boot_mode;
  logic       dbg_pin, dbg_oe, sys_n, clkr_n, core_n, phy_n;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  assign dbg_pin = !(dbg_oe || dbg_drv);

  rst_ctrl #(.FILT_LEN(FL), .STRETCH(ST), .BOOT_W(4), .DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_rst_ni(dbg_pin), .dbg_rst_oe_o(dbg_oe),
    .wd_req_i(wd_req), .boot_i(boot), .mgmt_en_i(mgmt_en), .sw_phy_rst_ni(sw_phy_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .boot_mode_o(boot_mode), .sys_rst_no(sys_n), .clk_rst_no(clkr_n),
    .core_rst_no(core_n), .phy_rst_no(phy_n)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // caller has already passed the request edge (k = 1)
  task automatic soft_pulse(bit core_hit);
    for (int k = 1; k <= ST + 4; k++) begin
      if (k > 1) step(1);
      chk("R3 sys", sys_n, k >= ST + 3);
      chk("R4 clk", clkr_n, 1);
      chk("R2 oe", dbg_oe, 0);
      chk("R8 core", core_n, core_hit ? (k >= ST + 3) : 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 0; dbg_drv = 0; wd_req = 0; mgmt_en = 1; sw_phy_n = 1;
    we = 0; addr = 0; wdata = 0; boot = 4'hA;
    step(20);
    chk("R3 reset sys", sys_n, 0);
    chk("R4 reset clk", clkr_n, 0);
    chk("R2 reset oe", dbg_oe, 1);
    chk("R8 reset core", core_n, 0);
    chk("R9 reset phy", phy_n, 0);

    // power-on release, cycle by cycle
    rst_ni = 1;
    for (int k = 1; k <= FL + ST + 4; k++) begin
      step(1);
      chk("R3 por sys", sys_n, k >= FL + ST + 3);
      chk("R4 por clk", clkr_n, k >= FL + ST + 3);
      chk("R2 por oe", dbg_oe, k < FL + ST + 1);
      chk("R8 por core", core_n, k >= FL + ST + 3);
    end
    chk("R5 boot", boot_mode, 4'hA);
    rd(2'd3, rv); chk("R5 boot reg", rv, 8'h0A);
    rd(2'd1, rv); chk("R6 cause por", rv, 8'h01);
    rd(2'd0, rv); chk("R10 ctrl por", rv, 8'h00);
    rd(2'd2, rv); chk("R10 phy por", rv, 8'h00);
    boot = 4'h6;

    // glitch sweep on both lines
    for (int ln = 0; ln < 2; ln++) begin
      for (int len = 1; len < FL; len++) begin
        int seen = 0;
        for (int i = 0; i < len + FL + 8; i++) begin
          if (ln == 0) rst_ni = (i >= len);
          else         dbg_drv = (i < len);
          step(1);
          if (!sys_n || !clkr_n || !core_n || dbg_oe) seen++;
        end
        chk(ln == 0 ? "R1 por glitch" : "R1 dbg glitch", seen, 0);
      end
    end
    rd(2'd1, rv); chk("R1 cause after glitches", rv, 8'h01);
    chk("R5 straps ignored", boot_mode, 4'hA);

    // watchdog, switch reset disabled
    wd_req = 1; step(1); wd_req = 0;
    soft_pulse(0);
    rd(2'd1, rv); chk("R6 cause wd", rv, 8'h03);
    chk("R5 boot after wd", boot_mode, 4'hA);

    // software reset, switch reset disabled
    wr(2'd0, 8'h01);
    rd(2'd0, rv); chk("R7 swrst pending", rv[0], 1);
    soft_pulse(0);
    rd(2'd0, rv); chk("R7 swrst cleared", rv, 8'h00);
    rd(2'd1, rv); chk("R6 cause sw", rv, 8'h07);

    // switch reset enabled
    wr(2'd0, 8'h02);
    wd_req = 1; step(1); wd_req = 0;
    soft_pulse(1);
    rd(2'd0, rv); chk("R10 en kept after wd", rv, 8'h02);
    wr(2'd0, 8'h03);
    soft_pulse(1);
    rd(2'd0, rv); chk("R7 clear with en", rv, 8'h02);

    // debugger reset from outside
    boot = 4'h9;
    dbg_drv = 1;
    for (int k = 1; k <= DB + FL + ST + 4; k++) begin
      step(1);
      if (k == DB) dbg_drv = 0;
      chk("R3 dbg sys", sys_n, !(k >= FL + 2 && k < DB + FL + ST + 3));
      chk("R8 dbg core", core_n, !(k >= FL + 2 && k < DB + FL + ST + 3));
      chk("R4 dbg clk", clkr_n, 1);
      chk("R2 dbg oe", dbg_oe, 0);
    end
    chk("R5 boot after dbg", boot_mode, 4'hA);
    rd(2'd0, rv); chk("R10 en kept after dbg", rv, 8'h02);

    // PHY source select
    for (int m = 0; m < 4; m++) begin
      mgmt_en = m[0]; sw_phy_n = m[1];
      #1 chk("R9 sel0", phy_n, 1);
    end
    wr(2'd2, 8'h01);
    for (int m = 0; m < 4; m++) begin
      mgmt_en = m[0]; sw_phy_n = m[1];
      #1 chk("R9 sel1", phy_n, m[0] & m[1]);
    end
    mgmt_en = 1; sw_phy_n = 1;
    wd_req = 1; step(1); wd_req = 0;
    step(ST + 4);
    rd(2'd2, rv); chk("R10 sel kept", rv, 8'h01);

    // second power-on: straps resampled, registers cleared
    boot = 4'h5;
    rst_ni = 0; step(FL); rst_ni = 1;
    step(FL + ST + 2);
    chk("R3 por2 still low", sys_n, 0);
    step(1);
    chk("R3 por2 released", sys_n, 1);
    chk("R5 boot por2", boot_mode, 4'h5);
    rd(2'd1, rv); chk("R6 cause por2", rv, 8'h01);
    rd(2'd0, rv); chk("R10 ctrl por2", rv, 8'h00);
    rd(2'd2, rv); chk("R10 sel por2", rv, 8'h00);

    summary();
    $finish;
  end
endmodule